// File: doc/BRIEF.md
# Address-Sequence Command Decoder

This block sits beside the host port of an asynchronous memory and watches its read traffic for a hidden command channel. A host issues a command by performing six reads in a row. The first five reads go to a fixed chain of addresses. The sixth read goes to one of four addresses, and that address selects the command. When the chain completes, the block raises exactly one of four command outputs for a single clock cycle: nonvolatile store, nonvolatile recall, power-loss auto-save off, or power-loss auto-save on.

The host strobes are asynchronous. They are brought into the block's clock domain and turned into one event per completed access. An access ends when chip-enable is released, or when output-enable is released while chip-enable stays low. Matching looks only at the low 16 address bits. The reads that make up a command still reach the array as ordinary reads; the array and the execution of the commands belong to other blocks.

Top module: `addr_seq_decoder`

## Requirements
- R1: After reset all four command outputs are low, and the matcher expects the first prefix address.
- R2: Reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F and then 0x8FC0, in that order, give exactly one pulse on `cmd_store`.
- R3: The same five-read prefix followed by 0x4C63 pulses `cmd_recall`, followed by 0x8B45 pulses `cmd_autosave_off`, and followed by 0x4B46 pulses `cmd_autosave_on`.
- R4: Only `host_addr[15:0]` takes part in matching. Address bits 16 and above have no effect on which command is decoded.
- R5: An access during which `host_we_n` was low counts as a write. A write at any step aborts the chain and issues no command.
- R6: A read whose address does not fit the current step aborts the chain. If that address equals 0x4E38, the matcher restarts with that read counted as the first step.
- R7: A step is counted when chip-enable is released, or when output-enable is released while chip-enable stays low. Whether `host_oe_n` was asserted during a chip-enable controlled read does not matter, and each access is counted only once.
- R8: A completed chain while `ctrl_busy` is high issues no command. Whether a command is issued or dropped, a completed chain returns the matcher to the first step.
- R9: Command outputs are registered. At most one is high in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ce_n | input | 1 | Host chip-enable, active low, asynchronous |
| host_oe_n | input | 1 | Host output-enable, active low, asynchronous |
| host_we_n | input | 1 | Host write-enable, active low, asynchronous |
| host_addr | input | ADDR_W | Host address; only bits 15:0 are compared |
| ctrl_busy | input | 1 | High while the command executor cannot accept commands |
| cmd_store | output | 1 | One-cycle pulse: store command |
| cmd_recall | output | 1 | One-cycle pulse: recall command |
| cmd_autosave_off | output | 1 | One-cycle pulse: disable auto-save on power loss |
| cmd_autosave_on | output | 1 | One-cycle pulse: enable auto-save on power loss |

## Verification
The assertions assume that each host strobe level lasts longer than the synchronizer depth. They also assume that the address and write-enable are steady for a few clocks before the strobe that ends an access. Without this, the synchronized address could be caught mid-change and an access could be lost or counted twice. The bench holds every address, enable and strobe phase for four clocks, and it changes them only at falling clock edges. It therefore never produces a skewed multi-bit sample, and every access ending turns into exactly one event.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;
  localparam int KEY_W      = 16;
  localparam int PREFIX_LEN = 5;
  localparam int NUM_CMD    = 4;

  typedef enum logic [1:0] {
    OP_STORE  = 2'd0,
    OP_RECALL = 2'd1,
    OP_ASOFF  = 2'd2,
    OP_ASON   = 2'd3
  } op_e;

  // one completed host access, as seen in the clock domain
  typedef struct packed {
    logic             valid;
    logic             wr;
    logic [KEY_W-1:0] key;
  } access_t;

  function automatic logic [KEY_W-1:0] prefix_key(input int idx);
    case (idx)
      0:       prefix_key = 16'h4E38;
      1:       prefix_key = 16'hB1C7;
      2:       prefix_key = 16'h83E0;
      3:       prefix_key = 16'h7C1F;
      default: prefix_key = 16'h703F;
    endcase
  endfunction

  function automatic logic [KEY_W-1:0] op_key(input int idx);
    case (idx)
      0:       op_key = 16'h8FC0;
      1:       op_key = 16'h4C63;
      2:       op_key = 16'h8B45;
      default: op_key = 16'h4B46;
    endcase
  endfunction
endpackage

// File: rtl/seqcmd_sync.sv
module seqcmd_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/seqcmd_access.sv
module seqcmd_access
  import seqcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_s,
  input  logic             oe_s,
  input  logic             we_s,
  input  logic [KEY_W-1:0] key_s,
  output access_t          ev
);
  logic             ce_d, oe_d, open_q, wr_q;
  logic [KEY_W-1:0] key_q;
  logic             ce_fall, ce_rise, oe_fall, oe_rise, close;

  always_comb begin
    ce_fall = ce_d & ~ce_s;
    ce_rise = ~ce_d & ce_s;
    oe_fall = oe_d & ~oe_s & ~ce_s;
    oe_rise = ~oe_d & oe_s & ~ce_s;
    close   = open_q & (ce_rise | oe_rise);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_d   <= 1'b1;
      oe_d   <= 1'b1;
      open_q <= 1'b0;
      wr_q   <= 1'b0;
      key_q  <= '0;
      ev     <= '0;
    end else begin
      ce_d     <= ce_s;
      oe_d     <= oe_s;
      ev.valid <= close;
      ev.wr    <= wr_q | (~ce_s & ~we_s);
      ev.key   <= key_q;
      if (close) begin
        open_q <= 1'b0;
        wr_q   <= 1'b0;
      end else begin
        if (ce_fall | oe_fall) open_q <= 1'b1;
        if (~ce_s & ~we_s)     wr_q   <= 1'b1;
      end
      if (~ce_s) key_q <= key_s;
    end
  end

  // each access is reported once; a new one must open first
  assert_single_event_R7: assert property (@(posedge clk) disable iff (rst)
    ev.valid |=> !ev.valid);
endmodule

// File: rtl/seqcmd_match.sv
module seqcmd_match
  import seqcmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               busy,
  input  access_t            ev,
  output logic [NUM_CMD-1:0] cmd
);
  localparam int STEP_W = $clog2(PREFIX_LEN + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);

  logic [STEP_W-1:0]  step_q;
  logic [NUM_CMD-1:0] hit;
  logic               pre_hit, first_hit, at_last;

  genvar g;
  generate
    for (g = 0; g < NUM_CMD; g++) begin : g_hit
      assign hit[g] = (ev.key == op_key(g));
    end
  endgenerate

  always_comb begin
    pre_hit = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (step_q == STEP_W'(i) && ev.key == prefix_key(i)) pre_hit = 1'b1;
    end
    first_hit = (ev.key == prefix_key(0));
    at_last   = (step_q == LAST_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      cmd    <= '0;
    end else begin
      cmd <= '0;
      if (ev.valid) begin
        if (ev.wr) begin
          step_q <= '0;
        end else if (at_last && (|hit)) begin
          step_q <= '0;
          if (!busy) cmd <= hit;
        end else if (!at_last && pre_hit) begin
          step_q <= step_q + STEP_W'(1);
        end else begin
          step_q <= first_hit ? STEP_W'(1) : '0;
        end
      end
    end
  end

  assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd));
  assert_pulse_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    (|cmd) |=> (cmd == '0));
  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cmd == '0));
  assert_write_aborts_R5: assert property (@(posedge clk) disable iff (rst)
    (ev.valid && ev.wr) |=> (cmd == '0 && step_q == '0));
  assert_cmd_has_cause_R2: assert property (@(posedge clk) disable iff (rst)
    (|cmd) |-> $past(ev.valid));
  assert_step_range_R6: assert property (@(posedge clk) disable iff (rst)
    step_q <= LAST_STEP);
endmodule

// File: rtl/addr_seq_decoder.sv
module addr_seq_decoder
  import seqcmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_ce_n,
  input  logic              host_oe_n,
  input  logic              host_we_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              ctrl_busy,
  output logic              cmd_store,
  output logic              cmd_recall,
  output logic              cmd_autosave_off,
  output logic              cmd_autosave_on
);
  logic [2:0]         strobes_s;
  logic [KEY_W-1:0]   key_s;
  access_t            ev;
  logic [NUM_CMD-1:0] cmd;

  // upper address bits never take part in matching (R4)
  generate
    if (ADDR_W > KEY_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^host_addr[ADDR_W-1:KEY_W];
    end
  endgenerate

  seqcmd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_ctl (
    .clk(clk), .rst(rst),
    .d({host_ce_n, host_oe_n, host_we_n}),
    .q(strobes_s)
  );

  seqcmd_sync #(.W(KEY_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_key (
    .clk(clk), .rst(rst),
    .d(host_addr[KEY_W-1:0]),
    .q(key_s)
  );

  seqcmd_access u_access (
    .clk(clk), .rst(rst),
    .ce_s(strobes_s[2]), .oe_s(strobes_s[1]), .we_s(strobes_s[0]),
    .key_s(key_s),
    .ev(ev)
  );

  seqcmd_match u_match (
    .clk(clk), .rst(rst), .busy(ctrl_busy), .ev(ev), .cmd(cmd)
  );

  assign cmd_store        = cmd[OP_STORE];
  assign cmd_recall       = cmd[OP_RECALL];
  assign cmd_autosave_off = cmd[OP_ASOFF];
  assign cmd_autosave_on  = cmd[OP_ASON];

  initial begin
    assert_addr_width_R4: assert (ADDR_W >= KEY_W && SYNC_STAGES >= 2);
  end
endmodule

// File: tb/sim_addr_seq_decoder.sv
module sim_addr_seq_decoder;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          c_st, c_rc, c_off, c_on;

  int n_chk = 0, n_fail = 0;
  int cnt[4];
  int wide_err = 0;
  logic [3:0] prev_v = '0;

  always #5 clk = ~clk;

  addr_seq_decoder #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .host_ce_n(ce_n), .host_oe_n(oe_n), .host_we_n(we_n),
    .host_addr(addr), .ctrl_busy(busy),
    .cmd_store(c_st), .cmd_recall(c_rc), .cmd_autosave_off(c_off), .cmd_autosave_on(c_on)
  );

  // pulse monitor: counts each output, flags wide or overlapping pulses
  always @(negedge clk) begin
    logic [3:0] v;
    v = {c_on, c_off, c_rc, c_st};
    if (!rst) begin
      for (int k = 0; k < 4; k++) if (v[k]) cnt[k]++;
      if ((v & prev_v) != 0 || $countones(v) > 1) wide_err++;
    end
    prev_v = v;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int k = 0; k < 4; k++) cnt[k] = 0;
  endtask

  task automatic expect_cmds(input string req, input int s, input int r, input int f, input int n);
    repeat (10) @(negedge clk);
    check({req, " store"},  cnt[0], s);
    check({req, " recall"}, cnt[1], r);
    check({req, " as_off"}, cnt[2], f);
    check({req, " as_on"},  cnt[3], n);
    clear_counts();
  endtask

  // chip-enable controlled access; oe optionally asserted
  task automatic ce_access(input logic [AW-1:0] a, input bit wr, input bit use_oe);
    @(negedge clk);
    addr = a; we_n = ~wr;
    repeat (4) @(negedge clk);
    ce_n = 1'b0; oe_n = ~use_oe;
    repeat (4) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
  endtask

  // output-enable controlled read with chip-enable held low by caller
  task automatic oe_access(input logic [AW-1:0] a);
    @(negedge clk);
    addr = a;
    repeat (4) @(negedge clk);
    oe_n = 1'b0;
    repeat (4) @(negedge clk);
    oe_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] pfx(input int i);
    case (i)
      0: pfx = 16'h4E38; 1: pfx = 16'hB1C7; 2: pfx = 16'h83E0;
      3: pfx = 16'h7C1F; default: pfx = 16'h703F;
    endcase
  endfunction

  task automatic full_seq(input logic [15:0] last, input logic [2:0] hi, input bit use_oe);
    for (int i = 0; i < 5; i++) ce_access({hi, pfx(i)}, 1'b0, use_oe);
    ce_access({hi, last}, 1'b0, use_oe);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 reset outputs", int'({c_on, c_off, c_rc, c_st}), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // first step is expected: only the command read, no prefix
    ce_access({3'b0, 16'h8FC0}, 1'b0, 1'b1);
    expect_cmds("R1 idle after reset", 0, 0, 0, 0);
  endtask

  task automatic t_store();
    full_seq(16'h8FC0, 3'b000, 1'b1);
    expect_cmds("R2 store", 1, 0, 0, 0);
  endtask

  task automatic t_others();
    full_seq(16'h4C63, 3'b000, 1'b1);
    expect_cmds("R3 recall", 0, 1, 0, 0);
    full_seq(16'h8B45, 3'b000, 1'b1);
    expect_cmds("R3 autosave off", 0, 0, 1, 0);
    full_seq(16'h4B46, 3'b000, 1'b1);
    expect_cmds("R3 autosave on", 0, 0, 0, 1);
  endtask

  task automatic t_upper();
    full_seq(16'h8FC0, 3'b101, 1'b1);
    expect_cmds("R4 upper bits set", 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) ce_access({3'(i + 1), pfx(i)}, 1'b0, 1'b1);
    ce_access({3'b111, 16'h4B46}, 1'b0, 1'b1);
    expect_cmds("R4 upper bits vary", 0, 0, 0, 1);
  endtask

  task automatic t_write();
    for (int i = 0; i < 3; i++) ce_access({3'b0, pfx(i)}, 1'b0, 1'b1);
    ce_access({3'b0, pfx(3)}, 1'b1, 1'b0);
    ce_access({3'b0, pfx(4)}, 1'b0, 1'b1);
    ce_access({3'b0, 16'h8FC0}, 1'b0, 1'b1);
    expect_cmds("R5 write mid prefix", 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) ce_access({3'b0, pfx(i)}, 1'b0, 1'b1);
    ce_access({3'b0, 16'h4C63}, 1'b1, 1'b0);
    expect_cmds("R5 write as last step", 0, 0, 0, 0);
  endtask

  task automatic t_mismatch();
    for (int i = 0; i < 2; i++) ce_access({3'b0, pfx(i)}, 1'b0, 1'b1);
    ce_access({3'b0, 16'h1234}, 1'b0, 1'b1);
    for (int i = 2; i < 5; i++) ce_access({3'b0, pfx(i)}, 1'b0, 1'b1);
    ce_access({3'b0, 16'h8FC0}, 1'b0, 1'b1);
    expect_cmds("R6 foreign read aborts", 0, 0, 0, 0);
    ce_access({3'b0, pfx(0)}, 1'b0, 1'b1);
    ce_access({3'b0, pfx(1)}, 1'b0, 1'b1);
    full_seq(16'h4C63, 3'b000, 1'b1);
    expect_cmds("R6 restart on first address", 0, 1, 0, 0);
  endtask

  task automatic t_strobes();
    full_seq(16'h8B45, 3'b000, 1'b0);
    expect_cmds("R7 oe never asserted", 0, 0, 1, 0);
    @(negedge clk);
    ce_n = 1'b0;
    for (int i = 0; i < 5; i++) oe_access({3'b0, pfx(i)});
    oe_access({3'b0, 16'h8FC0});
    ce_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_cmds("R7 oe controlled reads", 1, 0, 0, 0);
  endtask

  task automatic t_busy();
    busy = 1'b1;
    full_seq(16'h8FC0, 3'b000, 1'b1);
    expect_cmds("R8 busy drops command", 0, 0, 0, 0);
    busy = 1'b0;
    ce_access({3'b0, 16'h8FC0}, 1'b0, 1'b1);
    expect_cmds("R8 idle after dropped", 0, 0, 0, 0);
    full_seq(16'h4C63, 3'b000, 1'b1);
    ce_access({3'b0, 16'h4B46}, 1'b0, 1'b1);
    expect_cmds("R8 idle after issued", 0, 1, 0, 0);
  endtask

  task automatic t_width();
    check("R9 pulse width and exclusivity", wide_err, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    clear_counts();
    t_reset();
    t_store();
    t_others();
    t_upper();
    t_write();
    t_mismatch();
    t_strobes();
    t_busy();
    t_width();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule